// File: doc/BRIEF.md
# Multi-Lane Flash Command Sequencer

This block is the controller side of a flash-style serial transaction that can use one, two or four data lanes. A transaction is launched by a single-cycle start request together with a set of configuration inputs. From then on the block holds chip-select low and walks through up to four phases in a fixed order: a command phase, an address phase, a dummy (wait) phase that exists only for reads, and a data phase. Each phase advances by one bit slot per tick. The tick comes from an external serial-rate divider, so every cycle in which the tick is low leaves the outputs unchanged.

The lanes are split into an output value, a per-lane output enable and a sampled input. Together these form four bidirectional pads. A two-bit transfer-type code chooses whether the command and address phases use a single lane or the data width. A two-bit format code chooses the data width. During a write, the block fetches one data word per frame from its word input and acknowledges each fetch. During a read, it releases all lanes for the dummy and data phases and returns each completed frame right-aligned with a one-cycle valid strobe. A done strobe marks the end of the transaction, and chip-select is released on the following cycle.

Top module: `qspi_phase_seq`

## Requirements
- R1: A start request is accepted only while chip-select is high (idle). Chip-select is low in the first cycle after acceptance. A start request, or a configuration change, while a transaction is in progress has no effect on that transaction and does not begin another.
- R2: Phases run in the order command, address, wait, data. Each tick ends exactly one bit slot. In a cycle without a tick, the lane outputs and enables do not change.
- R3: Transfer type 00 sends command and address on one lane. Type 01 sends the command on one lane and the address at the data width. Type 10 sends both at the data width. Type 11 behaves as 00.
- R4: Format code 0 selects one data lane, code 1 selects two lanes and codes 2 and 3 select four lanes.
- R5: Each slot carries the most significant remaining bits first. With two lanes, lane 1 carries the higher bit. With four lanes, lane 3 carries the highest bit. A one-lane phase drives lane 0 and samples read data on lane 1. An enabled lane count is always 0, 1, 2 or 4.
- R6: The command length (0 to 16 bits) and the address length (0 to 32 bits) are programmable. Each length must be a multiple of its phase's lane count. Only the low "length" bits of the command and address inputs are sent.
- R7: A read has a wait phase of exactly `wait_ticks` ticks, during which all output enables are low. A write has no wait phase, whatever `wait_ticks` holds.
- R8: A read keeps all output enables low during its data phase. It captures `frame_count` frames of `frame_bits` bits each (4 to 16 bits, a multiple of the data lane count; a count of 0 acts as 1). `rdata_valid` pulses in the cycle after the tick that ends each frame, with the frame right-aligned in `rdata` and the upper bits zero.
- R9: A write sends the low `frame_bits` bits of `wdata` for each frame, on the low data-width lanes with their enables high. The word is taken at the edge where its frame begins, and `wdata_ack` pulses in the following cycle.
- R10: A command, address or wait phase of zero length takes no cycle. The first slot falls in the cycle right after acceptance.
- R11: `done` is high for exactly one cycle, the cycle after the tick that ends the last data slot, with chip-select still low. Chip-select is high in the next cycle.
- R12: After reset, chip-select is high and the enables, `done`, `rdata_valid` and `wdata_ack` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-slot enable from the serial-rate divider |
| start | input | 1 | Request to begin a transaction |
| rd_mode | input | 1 | 1 = read, 0 = write |
| xfer_type | input | 2 | Lane-width split for command and address |
| lane_fmt | input | 2 | Data lane width code |
| inst_len | input | 5 | Command length in bits |
| inst_code | input | 16 | Command value, right-aligned |
| addr_len | input | 6 | Address length in bits |
| addr_val | input | 32 | Address value, right-aligned |
| wait_ticks | input | 4 | Dummy slots on reads |
| frame_bits | input | 5 | Bits per data frame |
| frame_count | input | 8 | Number of data frames |
| wdata | input | 16 | Current write word, right-aligned |
| wdata_ack | output | 1 | Write word taken in the previous edge |
| din | input | 4 | Sampled lane inputs |
| dout | output | 4 | Lane output values |
| oe | output | 4 | Lane output enables |
| cs_n | output | 1 | Chip-select, active low |
| done | output | 1 | End-of-transaction strobe |
| rdata | output | 16 | Last captured read frame, right-aligned |
| rdata_valid | output | 1 | Read frame strobe |

## Verification
The hardest situations to reach are the edges where one phase hands over to the next, or one frame to the next, in the same cycle as a slot ends. These include skipping several zero-length phases straight from acceptance into the data phase, and reloading a one-slot quad frame on consecutive ticks. The stimulus reaches them with transactions whose lengths collapse phases: zero command and address lengths, a write with a non-zero wait count, and 4-bit quad frames. Other transactions use a divided tick to exercise holding between slots. A busy-time start request with altered configuration is injected partway through one read to show it is ignored.

// File: rtl/qsq_pkg.sv
package qsq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_INST = 3'd1,
        PH_ADDR = 3'd2,
        PH_WAIT = 3'd3,
        PH_DATA = 3'd4,
        PH_DONE = 3'd5
    } qsq_phase_e;

    // per-edge strobes from the phase controller to the lane datapaths
    typedef struct packed {
        logic adv;        // a slot of a shifting phase ends at this edge
        logic ld_inst;    // command bits enter the shifter
        logic ld_addr;    // address bits enter the shifter
        logic ld_data;    // a data frame begins
        logic frame_end;  // the final slot of a data frame ends
    } qsq_step_t;

    // lane width is carried as log2 of the lane count
    function automatic logic [1:0] fmt_lw(input logic [1:0] fmt);
        case (fmt)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [1:0] inst_lw(input logic [1:0] tt, input logic [1:0] dlw);
        return (tt == 2'b10) ? dlw : 2'd0;
    endfunction

    function automatic logic [1:0] addr_lw(input logic [1:0] tt, input logic [1:0] dlw);
        return (tt == 2'b01 || tt == 2'b10) ? dlw : 2'd0;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] lw);
        case (lw)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/qsq_ctrl.sv
module qsq_ctrl
    import qsq_pkg::*;
#(
    parameter int INST_MAX = 16,
    parameter int ADDR_MAX = 32,
    parameter int WAIT_W   = 4,
    parameter int FB_MAX   = 16,
    parameter int FC_W     = 8,
    localparam int IL_W    = $clog2(INST_MAX + 1),
    localparam int AL_W    = $clog2(ADDR_MAX + 1),
    localparam int FB_W    = $clog2(FB_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             rd_mode,
    input  logic [1:0]       xfer_type,
    input  logic [1:0]       lane_fmt,
    input  logic [IL_W-1:0]  inst_len,
    input  logic [AL_W-1:0]  addr_len,
    input  logic [WAIT_W-1:0] wait_ticks,
    input  logic [FB_W-1:0]  frame_bits,
    input  logic [FC_W-1:0]  frame_count,
    output qsq_phase_e       phase,
    output logic [1:0]       cur_lw,
    output qsq_step_t        step
);
    localparam int M1   = (ADDR_MAX > INST_MAX) ? ADDR_MAX : INST_MAX;
    localparam int M2   = (M1 > FB_MAX) ? M1 : FB_MAX;
    localparam int CMAX = (M2 > (1 << WAIT_W)) ? M2 : (1 << WAIT_W);
    localparam int CNT_W = $clog2(CMAX + 1);

    qsq_phase_e       ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [FC_W-1:0]  frm_q, frm_d;

    logic [1:0] dlw, ilw, alw;
    logic [CNT_W-1:0] n_inst, n_addr, n_wait, n_frame;
    qsq_phase_e after_addr, after_inst, first_ph;
    logic slot_last;

    assign dlw = fmt_lw(lane_fmt);
    assign ilw = inst_lw(xfer_type, dlw);
    assign alw = addr_lw(xfer_type, dlw);

    assign n_inst  = CNT_W'(inst_len >> ilw);
    assign n_addr  = CNT_W'(addr_len >> alw);
    assign n_wait  = rd_mode ? CNT_W'(wait_ticks) : '0;
    assign n_frame = CNT_W'(frame_bits >> dlw);

    assign after_addr = (n_wait != '0) ? PH_WAIT : PH_DATA;
    assign after_inst = (n_addr != '0) ? PH_ADDR : after_addr;
    assign first_ph   = (n_inst != '0) ? PH_INST : after_inst;
    assign slot_last  = tick && (cnt_q == CNT_W'(1));

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        frm_d = frm_q;
        case (ph_q)
            PH_IDLE: if (start) begin
                ph_d  = first_ph;
                frm_d = (frame_count == '0) ? FC_W'(1) : frame_count;
            end
            PH_INST: if (tick) begin
                if (slot_last) ph_d = after_inst;
                else           cnt_d = cnt_q - 1'b1;
            end
            PH_ADDR: if (tick) begin
                if (slot_last) ph_d = after_addr;
                else           cnt_d = cnt_q - 1'b1;
            end
            PH_WAIT: if (tick) begin
                if (slot_last) ph_d = PH_DATA;
                else           cnt_d = cnt_q - 1'b1;
            end
            PH_DATA: if (tick) begin
                if (slot_last) begin
                    if (frm_q == FC_W'(1)) ph_d = PH_DONE;
                    else begin
                        frm_d = frm_q - 1'b1;
                        cnt_d = n_frame;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_DONE: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
        if (ph_d != ph_q) begin
            case (ph_d)
                PH_INST: cnt_d = n_inst;
                PH_ADDR: cnt_d = n_addr;
                PH_WAIT: cnt_d = n_wait;
                PH_DATA: cnt_d = n_frame;
                default: cnt_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            frm_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            frm_q <= frm_d;
        end
    end

    always_comb begin
        step.adv       = tick && (ph_q == PH_INST || ph_q == PH_ADDR || ph_q == PH_DATA);
        step.ld_inst   = (ph_q == PH_IDLE) && (ph_d == PH_INST);
        step.ld_addr   = (ph_d == PH_ADDR) && (ph_q != PH_ADDR);
        step.ld_data   = ((ph_d == PH_DATA) && (ph_q != PH_DATA)) ||
                         ((ph_q == PH_DATA) && (ph_d == PH_DATA) && slot_last);
        step.frame_end = (ph_q == PH_DATA) && slot_last;
    end

    always_comb begin
        case (ph_q)
            PH_INST: cur_lw = ilw;
            PH_ADDR: cur_lw = alw;
            PH_DATA: cur_lw = dlw;
            default: cur_lw = 2'd0;
        endcase
    end

    assign phase = ph_q;

    // R1: an idle start always leaves idle at the next edge
    a_r1_accept: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE && start) |=> (ph_q != PH_IDLE));

    // R11: the done cycle only follows an edge that carried a tick
    a_r11_done_after_tick: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DONE) |-> $past(tick));

    // R11: done lasts exactly one cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DONE) |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/qsq_txpath.sv
module qsq_txpath
    import qsq_pkg::*;
#(
    parameter int INST_MAX = 16,
    parameter int ADDR_MAX = 32,
    parameter int FB_MAX   = 16,
    localparam int IL_W    = $clog2(INST_MAX + 1),
    localparam int AL_W    = $clog2(ADDR_MAX + 1),
    localparam int FB_W    = $clog2(FB_MAX + 1),
    localparam int SH_A    = (ADDR_MAX > INST_MAX) ? ADDR_MAX : INST_MAX,
    localparam int SH_W    = (SH_A > FB_MAX) ? SH_A : FB_MAX
) (
    input  logic                clk,
    input  logic                rst,
    input  qsq_step_t           step,
    input  qsq_phase_e          phase,
    input  logic [1:0]          lw,
    input  logic                rd_mode,
    input  logic [IL_W-1:0]     inst_len,
    input  logic [INST_MAX-1:0] inst_code,
    input  logic [AL_W-1:0]     addr_len,
    input  logic [ADDR_MAX-1:0] addr_val,
    input  logic [FB_W-1:0]     frame_bits,
    input  logic [FB_MAX-1:0]   wdata,
    output logic [3:0]          dout,
    output logic [3:0]          oe,
    output logic                wdata_ack
);
    logic [SH_W-1:0] sh_q;
    logic [3:0]      top4;
    logic            drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            wdata_ack <= 1'b0;
        end else begin
            if (step.ld_inst)
                sh_q <= SH_W'(inst_code) << (SH_W - int'(inst_len));
            else if (step.ld_addr)
                sh_q <= SH_W'(addr_val) << (SH_W - int'(addr_len));
            else if (step.ld_data)
                sh_q <= SH_W'(wdata) << (SH_W - int'(frame_bits));
            else if (step.adv)
                sh_q <= sh_q << (1 << lw);
            wdata_ack <= step.ld_data && !rd_mode;
        end
    end

    assign top4 = sh_q[SH_W-1 -: 4];

    always_comb begin
        case (lw)
            2'd0:    dout = {3'b000, top4[3]};
            2'd1:    dout = {2'b00, top4[3:2]};
            default: dout = top4;
        endcase
    end

    assign drive = (phase == PH_INST) || (phase == PH_ADDR) ||
                   ((phase == PH_DATA) && !rd_mode);
    assign oe    = drive ? lane_mask(lw) : 4'b0000;

    // R5: never three lanes enabled
    a_r5_lane_count: assert property (@(posedge clk) disable iff (rst)
        $countones(oe) != 3);

endmodule

// File: rtl/qsq_rxpath.sv
module qsq_rxpath
    import qsq_pkg::*;
#(
    parameter int FB_MAX = 16,
    localparam int FB_W  = $clog2(FB_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  qsq_step_t         step,
    input  qsq_phase_e        phase,
    input  logic [1:0]        lw,
    input  logic              rd_mode,
    input  logic [FB_W-1:0]   frame_bits,
    input  logic [3:0]        din,
    output logic [FB_MAX-1:0] rdata,
    output logic              rdata_valid
);
    logic [FB_MAX-1:0] acc_q, acc_nx, fmask;
    logic [FB_MAX:0]   one_sh;
    logic [3:0]        grp;
    logic              capture;

    always_comb begin
        case (lw)
            2'd0:    grp = {3'b000, din[1]};
            2'd1:    grp = {2'b00, din[1:0]};
            default: grp = din;
        endcase
    end

    assign capture = step.adv && (phase == PH_DATA) && rd_mode;
    assign acc_nx  = (acc_q << (1 << lw)) | FB_MAX'(grp);
    assign one_sh  = (FB_MAX + 1)'(1) << frame_bits;
    assign fmask   = FB_MAX'(one_sh - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= '0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= 1'b0;
            if (capture) begin
                acc_q <= acc_nx;
                if (step.frame_end) begin
                    rdata       <= acc_nx & fmask;
                    rdata_valid <= 1'b1;
                end
            end
        end
    end

    // R8: a frame strobe always follows a captured slot
    a_r8_valid_after_capture: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> $past(capture));

endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
    import qsq_pkg::*;
#(
    parameter int INST_MAX = 16,
    parameter int ADDR_MAX = 32,
    parameter int WAIT_W   = 4,
    parameter int FB_MAX   = 16,
    parameter int FC_W     = 8,
    localparam int IL_W    = $clog2(INST_MAX + 1),
    localparam int AL_W    = $clog2(ADDR_MAX + 1),
    localparam int FB_W    = $clog2(FB_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                start,
    input  logic                rd_mode,
    input  logic [1:0]          xfer_type,
    input  logic [1:0]          lane_fmt,
    input  logic [IL_W-1:0]     inst_len,
    input  logic [INST_MAX-1:0] inst_code,
    input  logic [AL_W-1:0]     addr_len,
    input  logic [ADDR_MAX-1:0] addr_val,
    input  logic [WAIT_W-1:0]   wait_ticks,
    input  logic [FB_W-1:0]     frame_bits,
    input  logic [FC_W-1:0]     frame_count,
    input  logic [FB_MAX-1:0]   wdata,
    output logic                wdata_ack,
    input  logic [3:0]          din,
    output logic [3:0]          dout,
    output logic [3:0]          oe,
    output logic                cs_n,
    output logic                done,
    output logic [FB_MAX-1:0]   rdata,
    output logic                rdata_valid
);
    qsq_phase_e phase;
    qsq_step_t  step;
    logic [1:0] cur_lw;
    logic       accept;

    // configuration held for the life of a transaction
    logic                rd_q;
    logic [1:0]          tt_q, fmt_q;
    logic [IL_W-1:0]     il_q;
    logic [INST_MAX-1:0] ic_q;
    logic [AL_W-1:0]     al_q;
    logic [ADDR_MAX-1:0] av_q;
    logic [WAIT_W-1:0]   wt_q;
    logic [FB_W-1:0]     fb_q;

    // configuration as seen this cycle: live at acceptance, held otherwise
    logic                rd_c;
    logic [1:0]          tt_c, fmt_c;
    logic [IL_W-1:0]     il_c;
    logic [INST_MAX-1:0] ic_c;
    logic [AL_W-1:0]     al_c;
    logic [ADDR_MAX-1:0] av_c;
    logic [WAIT_W-1:0]   wt_c;
    logic [FB_W-1:0]     fb_c;

    assign accept = (phase == PH_IDLE) && start;

    assign rd_c  = accept ? rd_mode    : rd_q;
    assign tt_c  = accept ? xfer_type  : tt_q;
    assign fmt_c = accept ? lane_fmt   : fmt_q;
    assign il_c  = accept ? inst_len   : il_q;
    assign ic_c  = accept ? inst_code  : ic_q;
    assign al_c  = accept ? addr_len   : al_q;
    assign av_c  = accept ? addr_val   : av_q;
    assign wt_c  = accept ? wait_ticks : wt_q;
    assign fb_c  = accept ? frame_bits : fb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            tt_q  <= '0;
            fmt_q <= '0;
            il_q  <= '0;
            ic_q  <= '0;
            al_q  <= '0;
            av_q  <= '0;
            wt_q  <= '0;
            fb_q  <= '0;
        end else if (accept) begin
            rd_q  <= rd_mode;
            tt_q  <= xfer_type;
            fmt_q <= lane_fmt;
            il_q  <= inst_len;
            ic_q  <= inst_code;
            al_q  <= addr_len;
            av_q  <= addr_val;
            wt_q  <= wait_ticks;
            fb_q  <= frame_bits;
        end
    end

    qsq_ctrl #(
        .INST_MAX(INST_MAX), .ADDR_MAX(ADDR_MAX), .WAIT_W(WAIT_W),
        .FB_MAX(FB_MAX), .FC_W(FC_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .start(start),
        .rd_mode(rd_c), .xfer_type(tt_c), .lane_fmt(fmt_c),
        .inst_len(il_c), .addr_len(al_c), .wait_ticks(wt_c),
        .frame_bits(fb_c), .frame_count(frame_count),
        .phase(phase), .cur_lw(cur_lw), .step(step)
    );

    qsq_txpath #(
        .INST_MAX(INST_MAX), .ADDR_MAX(ADDR_MAX), .FB_MAX(FB_MAX)
    ) u_tx (
        .clk(clk), .rst(rst), .step(step), .phase(phase), .lw(cur_lw),
        .rd_mode(rd_c), .inst_len(il_c), .inst_code(ic_c),
        .addr_len(al_c), .addr_val(av_c), .frame_bits(fb_c),
        .wdata(wdata), .dout(dout), .oe(oe), .wdata_ack(wdata_ack)
    );

    qsq_rxpath #(
        .FB_MAX(FB_MAX)
    ) u_rx (
        .clk(clk), .rst(rst), .step(step), .phase(phase), .lw(cur_lw),
        .rd_mode(rd_c), .frame_bits(fb_c), .din(din),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    assign cs_n = (phase == PH_IDLE);
    assign done = (phase == PH_DONE);

    // R2: lanes hold between ticks while selected
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cs_n) |=> ($stable(dout) && $stable(oe)));

    // R11: chip-select is released right after done
    a_r11_cs_release: assert property (@(posedge clk) disable iff (rst)
        done |=> cs_n);

endmodule

// File: tb/sim_qspi_phase_seq.sv
module sim_qspi_phase_seq;

    logic        clk = 1'b0;
    logic        rst, tick, start, rd_mode;
    logic [1:0]  xfer_type, lane_fmt;
    logic [4:0]  inst_len, frame_bits;
    logic [15:0] inst_code, wdata, rdata;
    logic [5:0]  addr_len;
    logic [31:0] addr_val;
    logic [3:0]  wait_ticks, din, dout, oe;
    logic [7:0]  frame_count;
    logic        wdata_ack, cs_n, done, rdata_valid;

    int n_vec = 0;
    int n_bad = 0;

    // transaction description used by run_txn
    logic        t_rd;
    logic [1:0]  t_tt, t_fmt;
    int          t_il, t_al, t_wait, t_fb, t_nf;
    logic [15:0] t_inst;
    logic [31:0] t_addr;
    logic [15:0] wr_w [0:7];
    logic [15:0] rd_w [0:7];

    always #4 clk = ~clk;

    qspi_phase_seq u0 (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .rd_mode(rd_mode),
        .xfer_type(xfer_type), .lane_fmt(lane_fmt), .inst_len(inst_len),
        .inst_code(inst_code), .addr_len(addr_len), .addr_val(addr_val),
        .wait_ticks(wait_ticks), .frame_bits(frame_bits), .frame_count(frame_count),
        .wdata(wdata), .wdata_ack(wdata_ack), .din(din), .dout(dout), .oe(oe),
        .cs_n(cs_n), .done(done), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int grp_of(input logic [31:0] val, input int len, input int k, input int w);
        return int'((val >> (len - (k + 1) * w)) & ((32'd1 << w) - 1));
    endfunction

    function automatic int msk(input int w);
        return (1 << w) - 1;
    endfunction

    task automatic run_txn(input int div, input int poke);
        int dwl, iwl, awl, n_i, n_a, n_w, spf, n_d, total;
        int slot, cyc, widx, rfr, s, f, k, g, oe_e;
        string tag;
        dwl = (t_fmt == 2'd0) ? 1 : (t_fmt == 2'd1) ? 2 : 4;
        iwl = (t_tt == 2'b10) ? dwl : 1;
        awl = (t_tt == 2'b01 || t_tt == 2'b10) ? dwl : 1;
        n_i = t_il / iwl;
        n_a = t_al / awl;
        n_w = t_rd ? t_wait : 0;
        spf = t_fb / dwl;
        n_d = t_nf * spf;
        total = n_i + n_a + n_w + n_d;

        @(negedge clk);
        rd_mode = t_rd; xfer_type = t_tt; lane_fmt = t_fmt;
        inst_len = 5'(t_il); inst_code = t_inst; addr_len = 6'(t_al);
        addr_val = t_addr; wait_ticks = 4'(t_wait); frame_bits = 5'(t_fb);
        frame_count = 8'(t_nf); wdata = wr_w[0]; tick = 1'b0; start = 1'b1;
        widx = 0; rfr = 0;
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b0, "R1 cs low after accept", cs_n, 0);

        slot = 0; cyc = 0;
        while (slot < total && cyc < 4000) begin
            start = 1'b0;
            if (wdata_ack) begin widx++; wdata = wr_w[widx < 8 ? widx : 7]; end
            if (rdata_valid) begin
                chk(rdata == (rd_w[rfr] & 16'(msk(t_fb))), "R8 read frame",
                    rdata, rd_w[rfr] & 16'(msk(t_fb)));
                rfr++;
            end
            tick = ((cyc % div) == 0);
            if (tick && slot == poke) begin
                // busy-time request with altered configuration (R1)
                start = 1'b1; rd_mode = ~t_rd; xfer_type = 2'b10; lane_fmt = 2'd2;
                inst_len = 5'd0; addr_len = 6'd0; wait_ticks = 4'd0;
            end
            if (tick) begin
                s = slot; g = 0; oe_e = 0; din = 4'b1111;
                if (s < n_i) begin
                    g = grp_of({16'h0, t_inst}, t_il, s, iwl); oe_e = msk(iwl);
                    tag = "R3 R5 R6 command slot";
                end else if (s < n_i + n_a) begin
                    g = grp_of(t_addr, t_al, s - n_i, awl); oe_e = msk(awl);
                    tag = "R3 R5 R6 address slot";
                end else if (s < n_i + n_a + n_w) begin
                    tag = "R7 wait slot";
                end else begin
                    f = (s - n_i - n_a - n_w) / spf;
                    k = (s - n_i - n_a - n_w) % spf;
                    if (t_rd) begin
                        g = grp_of({16'h0, rd_w[f]}, t_fb, k, dwl);
                        if (dwl == 1) din = {2'b11, g[0], 1'b1};
                        else if (dwl == 2) din = {2'b11, g[1:0]};
                        else din = g[3:0];
                        tag = "R4 R8 read data slot";
                        g = 0;
                    end else begin
                        g = grp_of({16'h0, wr_w[f]}, t_fb, k, dwl); oe_e = msk(dwl);
                        tag = "R4 R5 R9 write data slot";
                    end
                end
                #1;
                chk(oe == 4'(oe_e), {tag, " oe"}, oe, oe_e);
                chk((dout & 4'(oe_e)) == 4'(g), {tag, " lanes"}, dout & 4'(oe_e), g);
                chk(cs_n == 1'b0 && done == 1'b0, "R2 selected mid-transaction", {cs_n, done}, 0);
                slot++;
            end
            cyc++;
            @(negedge clk);
        end
        tick = 1'b0; start = 1'b0;
        if (rdata_valid) begin
            chk(rdata == (rd_w[rfr] & 16'(msk(t_fb))), "R8 last read frame",
                rdata, rd_w[rfr] & 16'(msk(t_fb)));
            rfr++;
        end
        if (div == 1)
            chk(cyc == total, "R10 R2 slot count equals cycle count", cyc, total);
        chk(done == 1'b1 && cs_n == 1'b0, "R11 done after last slot", {done, cs_n}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0 && cs_n == 1'b1, "R11 cs released after done", {done, cs_n}, 2'b01);
        if (t_rd) chk(rfr == t_nf, "R8 frame count", rfr, t_nf);
        else      chk(widx == t_nf, "R9 write words acknowledged", widx, t_nf);
    endtask

    task automatic t_reset;
        rst = 1'b1; tick = 1'b0; start = 1'b0; din = 4'h0; wdata = 16'h0;
        rd_mode = 1'b0; xfer_type = 2'b00; lane_fmt = 2'd0; inst_len = '0;
        inst_code = '0; addr_len = '0; addr_val = '0; wait_ticks = '0;
        frame_bits = 5'd8; frame_count = 8'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R12 cs after reset", cs_n, 1);
        chk(oe == 4'h0 && done == 1'b0, "R12 oe/done after reset", {oe, done}, 0);
        chk(rdata_valid == 1'b0 && wdata_ack == 1'b0, "R12 strobes after reset",
            {rdata_valid, wdata_ack}, 0);
    endtask

    task automatic t_std_write;
        t_rd = 0; t_tt = 2'b00; t_fmt = 2'd0; t_il = 8; t_inst = 16'h5A02;
        t_al = 24; t_addr = 32'hFF12_34C5; t_wait = 7; t_fb = 8; t_nf = 2;
        wr_w[0] = 16'hA5C3; wr_w[1] = 16'h0F96; wr_w[2] = 16'h0;
        run_txn(1, -1);
    endtask

    task automatic t_quad_read;
        t_rd = 1; t_tt = 2'b10; t_fmt = 2'd2; t_il = 8; t_inst = 16'h00EB;
        t_al = 24; t_addr = 32'h00A1_B2C3; t_wait = 6; t_fb = 16; t_nf = 3;
        rd_w[0] = 16'h1234; rd_w[1] = 16'hFEDC; rd_w[2] = 16'h8001;
        run_txn(1, -1);
    endtask

    task automatic t_dual_read_slow;
        t_rd = 1; t_tt = 2'b01; t_fmt = 2'd1; t_il = 8; t_inst = 16'h003B;
        t_al = 16; t_addr = 32'h0000_9C4E; t_wait = 2; t_fb = 8; t_nf = 2;
        rd_w[0] = 16'h00C6; rd_w[1] = 16'h0039;
        run_txn(3, -1);
    endtask

    task automatic t_quad_write_bare;
        t_rd = 0; t_tt = 2'b10; t_fmt = 2'd3; t_il = 0; t_inst = 16'hFFFF;
        t_al = 0; t_addr = 32'hFFFF_FFFF; t_wait = 5; t_fb = 4; t_nf = 3;
        wr_w[0] = 16'hFFF9; wr_w[1] = 16'h0006; wr_w[2] = 16'h00AC; wr_w[3] = 16'h0;
        run_txn(1, -1);
    endtask

    task automatic t_std_read_busy_start;
        t_rd = 1; t_tt = 2'b00; t_fmt = 2'd0; t_il = 8; t_inst = 16'h0003;
        t_al = 8; t_addr = 32'h0000_0071; t_wait = 0; t_fb = 12; t_nf = 1;
        rd_w[0] = 16'h0B2D;
        run_txn(1, 10);
        // the ignored request must not have opened a second transaction (R1)
        repeat (3) begin
            @(negedge clk);
            chk(cs_n == 1'b1, "R1 no transaction from busy request", cs_n, 1);
        end
    endtask

    task automatic t_type11;
        t_rd = 0; t_tt = 2'b11; t_fmt = 2'd2; t_il = 4; t_inst = 16'h000B;
        t_al = 4; t_addr = 32'h0000_0006; t_wait = 0; t_fb = 8; t_nf = 1;
        wr_w[0] = 16'h003C; wr_w[1] = 16'h0;
        run_txn(2, -1);
    endtask

    initial begin
        t_reset();
        t_std_write();
        t_quad_read();
        t_dual_read_slow();
        t_quad_write_bare();
        t_std_read_busy_start();
        t_type11();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule